// File: doc/BRIEF.md
# Dispatch Register Scoreboard

This block is the hazard check of an in-order dispatch stage. It holds one pending bit per general-purpose register. A set bit means an instruction already sent to a functional unit will write that register. A clear bit means the register's current value is usable. Each cycle the stage presents at most one decoded instruction of the shape `dst = op(srcA, srcB)`. Each operand carries an index and a use flag. The block answers in the same cycle with a grant or a stall.

A granted instruction marks its destination pending. Functional units report finished writes on one or more completion ports, in any order. Each report clears the bit of the register it names. A report that arrives in the same cycle as a check is already visible to that check. A stalled instruction stays on the inputs and is checked again every cycle until it is granted. Register 0 can be configured as a constant-zero register that is never tracked.

Top module: `dispatch_scoreboard`

## Requirements
- R1: While `rst_n` is low all pending bits are zero. After `rst_n` rises, the block grants nothing until two clock edges have passed. During that time a valid instruction reports `stall`.
- R2: A valid instruction whose used source A or used source B is pending is not granted and raises `stall` (read-after-write). A source whose use flag is low is never checked.
- R3: A valid instruction whose used destination is pending is not granted and raises `stall` (write-after-write).
- R4: A valid instruction with neither hazard raises `dispatch` in the same cycle. If its destination is used, the destination's bit reads 1 after the next clock edge. An unused destination marks nothing.
- R5: A valid completion report clears the named register's bit at the next clock edge. Reports on several ports in one cycle all take effect. A report for a register that is not pending changes nothing.
- R6: A completion report in a cycle counts as already applied by that cycle's hazard check. If the same register is cleared by a report and set by a grant in one cycle, it ends pending.
- R7: With `HARD_ZERO`=1, the bit for register 0 never reads 1 and register 0 never causes a stall.
- R8: A cycle without a grant sets no pending bit. A stalled instruction held at the inputs is granted in the first cycle in which its hazard is gone.
- R9: `dispatch` and `stall` are never both high. With `in_valid` low, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is presented |
| rs_vld | input | 1 | Source A is read |
| rs_idx | input | IW | Source A register index |
| rt_vld | input | 1 | Source B is read |
| rt_idx | input | IW | Source B register index |
| rd_vld | input | 1 | Destination is written |
| rd_idx | input | IW | Destination register index |
| cpl_vld | input | NCPL | Per-port completion valid |
| cpl_idx | input | NCPL*IW | Per-port completed register index, port p at bits [p*IW +: IW] |
| dispatch | output | 1 | Instruction is sent this cycle |
| stall | output | 1 | Instruction is held this cycle |
| pending | output | NREG | Registered pending bit per register |

## Verification
The bench builds the block with eight registers, two completion ports and register 0 fixed at zero. With only eight registers, every pending bit can be filled and then drained one by one in a scrambled order. With two ports, two completions can arrive in the same cycle, and a completion can coincide with a grant on the same register. The zero register setting makes it possible to try writes to register 0 and confirm that they are never tracked.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Outcome of the per-cycle hazard evaluation
  typedef enum logic [1:0] {
    HZ_NONE = 2'd0,
    HZ_RAW  = 2'd1,
    HZ_WAW  = 2'd2
  } hz_kind_e;

endpackage

// File: rtl/sb_rst_sync.sv
module sb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);

  logic stage1_q;
  logic stage2_q;

  // Assert asynchronously, release after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign run_n = stage2_q;

endmodule

// File: rtl/sb_clear_decode.sv
module sb_clear_decode #(
  parameter int NREG = 32,
  parameter int NCPL = 2,
  parameter int IW   = 5
) (
  input  logic [NCPL-1:0]    cpl_vld,
  input  logic [NCPL*IW-1:0] cpl_idx,
  output logic [NREG-1:0]    clr_mask
);

  // Merge every completion port into one clear vector
  always_comb begin
    clr_mask = '0;
    for (int p = 0; p < NCPL; p++) begin
      for (int r = 0; r < NREG; r++) begin
        if (cpl_vld[p] && (cpl_idx[p*IW +: IW] == IW'(r))) begin
          clr_mask[r] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sb_hazard.sv
module sb_hazard
  import sb_pkg::*;
#(
  parameter int NREG      = 32,
  parameter int IW        = 5,
  parameter bit HARD_ZERO = 1'b1
) (
  input  logic            in_valid,
  input  logic            run,
  input  logic            rs_vld,
  input  logic [IW-1:0]   rs_idx,
  input  logic            rt_vld,
  input  logic [IW-1:0]   rt_idx,
  input  logic            rd_vld,
  input  logic [IW-1:0]   rd_idx,
  input  logic [NREG-1:0] pend_eff,
  output logic            grant,
  output logic            hold,
  output logic [NREG-1:0] set_mask
);

  logic [NREG-1:0] sel_rs;
  logic [NREG-1:0] sel_rt;
  logic [NREG-1:0] sel_rd;
  logic            busy_src;
  logic            busy_dst;
  hz_kind_e        kind;

  // Per-register index match, one comparator per register
  for (genvar r = 0; r < NREG; r++) begin : g_sel
    assign sel_rs[r] = (rs_idx == IW'(r));
    assign sel_rt[r] = (rt_idx == IW'(r));
    assign sel_rd[r] = (rd_idx == IW'(r));
  end

  always_comb begin
    busy_src = (rs_vld && |(sel_rs & pend_eff)) ||
               (rt_vld && |(sel_rt & pend_eff));
    busy_dst = rd_vld && |(sel_rd & pend_eff);
    if (busy_src) begin
      kind = HZ_RAW;
    end else if (busy_dst) begin
      kind = HZ_WAW;
    end else begin
      kind = HZ_NONE;
    end
  end

  assign grant = in_valid && run && (kind == HZ_NONE);
  assign hold  = in_valid && !grant;

  // Destination marking; register 0 is untracked when hardwired
  for (genvar r = 0; r < NREG; r++) begin : g_set
    if (HARD_ZERO && (r == 0)) begin : g_zero
      assign set_mask[r] = 1'b0;
    end else begin : g_track
      assign set_mask[r] = grant && rd_vld && sel_rd[r];
    end
  end

endmodule

// File: rtl/sb_state.sv
module sb_state #(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic [NREG-1:0] clr_mask,
  input  logic [NREG-1:0] set_mask,
  output logic [NREG-1:0] pend_q
);

  logic [NREG-1:0] pend_d;
  logic            pend_en;

  // Next state: clears first, then the new mark wins
  always_comb begin
    pend_d  = (pend_q & ~clr_mask) | set_mask;
    pend_en = (|clr_mask) || (|set_mask);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/dispatch_scoreboard.sv
module dispatch_scoreboard #(
  parameter int NREG      = 32,
  parameter int NCPL      = 2,
  parameter bit HARD_ZERO = 1'b1,
  localparam int IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              rs_vld,
  input  logic [IW-1:0]     rs_idx,
  input  logic              rt_vld,
  input  logic [IW-1:0]     rt_idx,
  input  logic              rd_vld,
  input  logic [IW-1:0]     rd_idx,
  input  logic [NCPL-1:0]   cpl_vld,
  input  logic [NCPL*IW-1:0] cpl_idx,
  output logic              dispatch,
  output logic              stall,
  output logic [NREG-1:0]   pending
);

  logic            run_n;
  logic [NREG-1:0] clr_mask;
  logic [NREG-1:0] set_mask;
  logic [NREG-1:0] pend_q;
  logic [NREG-1:0] pend_eff;

  sb_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  sb_clear_decode #(
    .NREG (NREG),
    .NCPL (NCPL),
    .IW   (IW)
  ) u_clr (
    .cpl_vld  (cpl_vld),
    .cpl_idx  (cpl_idx),
    .clr_mask (clr_mask)
  );

  // Same-cycle completions are seen by the check
  assign pend_eff = pend_q & ~clr_mask;

  sb_hazard #(
    .NREG      (NREG),
    .IW        (IW),
    .HARD_ZERO (HARD_ZERO)
  ) u_hz (
    .in_valid (in_valid),
    .run      (run_n),
    .rs_vld   (rs_vld),
    .rs_idx   (rs_idx),
    .rt_vld   (rt_vld),
    .rt_idx   (rt_idx),
    .rd_vld   (rd_vld),
    .rd_idx   (rd_idx),
    .pend_eff (pend_eff),
    .grant    (dispatch),
    .hold     (stall),
    .set_mask (set_mask)
  );

  sb_state #(
    .NREG (NREG)
  ) u_st (
    .clk      (clk),
    .arst_n   (run_n),
    .clr_mask (clr_mask),
    .set_mask (set_mask),
    .pend_q   (pend_q)
  );

  assign pending = pend_q;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NREG      = 32,
  parameter int NCPL      = 2,
  parameter bit HARD_ZERO = 1'b1,
  parameter int IW        = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              rs_vld,
  input logic [IW-1:0]     rs_idx,
  input logic              rt_vld,
  input logic [IW-1:0]     rt_idx,
  input logic              rd_vld,
  input logic [IW-1:0]     rd_idx,
  input logic [NCPL-1:0]   cpl_vld,
  input logic [NCPL*IW-1:0] cpl_idx,
  input logic              dispatch,
  input logic              stall,
  input logic [NREG-1:0]   pending
);

  logic busy_rs;
  logic busy_rt;
  logic busy_rd;

  // Independent model: pending and not being completed this cycle
  always_comb begin
    busy_rs = 1'b0;
    busy_rt = 1'b0;
    busy_rd = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      logic hit;
      hit = 1'b0;
      for (int p = 0; p < NCPL; p++) begin
        if (cpl_vld[p] && cpl_idx[p*IW +: IW] == IW'(r)) hit = 1'b1;
      end
      if (pending[r] && !hit) begin
        if (rs_idx == IW'(r)) busy_rs = 1'b1;
        if (rt_idx == IW'(r)) busy_rt = 1'b1;
        if (rd_idx == IW'(r)) busy_rd = 1'b1;
      end
    end
  end

  // R9
  excl_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dispatch && stall));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!dispatch && !stall));

  // R2
  raw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ((rs_vld && busy_rs) || (rt_vld && busy_rt)) |-> (stall && !dispatch));

  // R3
  waw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rd_vld && busy_rd |-> (stall && !dispatch));

  // R4
  mark_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch && rd_vld && (!HARD_ZERO || rd_idx != '0) |=> pending[$past(rd_idx)]);

  // R5
  clear_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_vld[0] && !(dispatch && rd_vld && rd_idx == cpl_idx[IW-1:0])
    |=> !pending[$past(cpl_idx[IW-1:0])]);

  // R6
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && $past(rst_n, 1) && $past(rst_n, 2) && !rs_vld && !rt_vld &&
    rd_vld && cpl_vld[0] && cpl_idx[IW-1:0] == rd_idx |-> dispatch);

  // R8
  no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dispatch |=> ((pending & ~$past(pending)) == '0));

  if (HARD_ZERO) begin : g_zero_chk
    // R7
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pending[0]);
  end

endmodule

bind dispatch_scoreboard sb_checker #(
  .NREG      (NREG),
  .NCPL      (NCPL),
  .HARD_ZERO (HARD_ZERO),
  .IW        (IW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .rs_vld   (rs_vld),
  .rs_idx   (rs_idx),
  .rt_vld   (rt_vld),
  .rt_idx   (rt_idx),
  .rd_vld   (rd_vld),
  .rd_idx   (rd_idx),
  .cpl_vld  (cpl_vld),
  .cpl_idx  (cpl_idx),
  .dispatch (dispatch),
  .stall    (stall),
  .pending  (pending)
);

// File: tb/sim_dispatch_scoreboard.sv
`timescale 1ns/1ps
module sim_dispatch_scoreboard;

  localparam int NREG = 8;
  localparam int NCPL = 2;
  localparam int IW   = 3;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic            rs_vld, rt_vld, rd_vld;
  logic [IW-1:0]   rs_idx, rt_idx, rd_idx;
  logic [NCPL-1:0] cpl_vld;
  logic [NCPL*IW-1:0] cpl_idx;
  logic            dispatch, stall;
  logic [NREG-1:0] pending;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  dispatch_scoreboard #(
    .NREG      (NREG),
    .NCPL      (NCPL),
    .HARD_ZERO (1'b1)
  ) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .rs_vld   (rs_vld),
    .rs_idx   (rs_idx),
    .rt_vld   (rt_vld),
    .rt_idx   (rt_idx),
    .rd_vld   (rd_vld),
    .rd_idx   (rd_idx),
    .cpl_vld  (cpl_vld),
    .cpl_idx  (cpl_idx),
    .dispatch (dispatch),
    .stall    (stall),
    .pending  (pending)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog R9: actual=%0d cycles expected=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  typedef struct packed {
    logic       iv;
    logic       sv; logic [2:0] s;
    logic       tv; logic [2:0] t;
    logic       dv; logic [2:0] d;
    logic       c0v; logic [2:0] c0;
    logic       c1v; logic [2:0] c1;
    logic       ed;
    logic       es;
    logic [7:0] ep;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    // R4 clean grant marks r1
    '{1'b1, 1'b1,3'd2, 1'b1,3'd3, 1'b1,3'd1, 1'b0,3'd0, 1'b0,3'd0, 1'b1,1'b0, 8'h02},
    // R2 read of pending r1 stalls; R8 nothing marked
    '{1'b1, 1'b1,3'd1, 1'b1,3'd5, 1'b1,3'd4, 1'b0,3'd0, 1'b0,3'd0, 1'b0,1'b1, 8'h02},
    // R6 R8 same instruction held, r1 completes this cycle
    '{1'b1, 1'b1,3'd1, 1'b1,3'd5, 1'b1,3'd4, 1'b1,3'd1, 1'b0,3'd0, 1'b1,1'b0, 8'h10},
    // R3 write to pending r4 stalls
    '{1'b1, 1'b1,3'd2, 1'b0,3'd0, 1'b1,3'd4, 1'b0,3'd0, 1'b0,3'd0, 1'b0,1'b1, 8'h10},
    // R5 port 1 clears r4 while r6 is marked
    '{1'b1, 1'b1,3'd0, 1'b1,3'd0, 1'b1,3'd6, 1'b0,3'd0, 1'b1,3'd4, 1'b1,1'b0, 8'h40},
    // R7 write to r0 is not tracked
    '{1'b1, 1'b1,3'd2, 1'b0,3'd0, 1'b1,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,1'b0, 8'h40},
    // R4 mark r3
    '{1'b1, 1'b1,3'd0, 1'b1,3'd0, 1'b1,3'd3, 1'b0,3'd0, 1'b0,3'd0, 1'b1,1'b0, 8'h48},
    // R2 unused sources name pending registers, ignored
    '{1'b1, 1'b0,3'd6, 1'b0,3'd3, 1'b1,3'd2, 1'b0,3'd0, 1'b0,3'd0, 1'b1,1'b0, 8'h4C},
    // R4 unused destination marks nothing
    '{1'b1, 1'b1,3'd7, 1'b0,3'd0, 1'b0,3'd5, 1'b0,3'd0, 1'b0,3'd0, 1'b1,1'b0, 8'h4C},
    // R9 no instruction, both outputs low
    '{1'b0, 1'b1,3'd6, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,1'b0, 8'h4C},
    // R5 two completions in one cycle
    '{1'b0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd6, 1'b1,3'd3, 1'b0,1'b0, 8'h04},
    // R6 clear and mark of r2 together, mark wins
    '{1'b1, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2, 1'b1,3'd2, 1'b0,3'd0, 1'b1,1'b0, 8'h04},
    // R5 completion of non-pending r5 has no effect, R2 r2 still blocks
    '{1'b1, 1'b0,3'd0, 1'b1,3'd2, 1'b1,3'd5, 1'b0,3'd0, 1'b1,3'd5, 1'b0,1'b1, 8'h04},
    // R5 drain r2
    '{1'b0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2, 1'b0,3'd0, 1'b0,1'b0, 8'h00}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0;
    rs_vld = 1'b0; rs_idx = '0;
    rt_vld = 1'b0; rt_idx = '0;
    rd_vld = 1'b0; rd_idx = '0;
    cpl_vld = '0;  cpl_idx = '0;
  endtask

  // Drive at negedge, check grant mid-phase, check state after the edge
  task automatic step(input vec_t v, input int n);
    @(negedge clk);
    in_valid = v.iv;
    rs_vld = v.sv; rs_idx = v.s;
    rt_vld = v.tv; rt_idx = v.t;
    rd_vld = v.dv; rd_idx = v.d;
    cpl_vld = {v.c1v, v.c0v};
    cpl_idx = {v.c1, v.c0};
    #2;
    check(dispatch == v.ed, $sformatf("row %0d R2 R3 R4 R6 R9 dispatch", n), dispatch, v.ed);
    check(stall == v.es, $sformatf("row %0d R2 R3 R8 R9 stall", n), stall, v.es);
    @(posedge clk);
    #1;
    check(pending == v.ep, $sformatf("row %0d R4 R5 R7 R8 pending", n), pending, v.ep);
  endtask

  initial begin
    logic [7:0] model;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(pending == 8'h00, "R1 pending in reset", pending, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i], i);
    end

    // R4 R5 fill r1..r7, then drain out of order
    model = 8'h00;
    for (int k = 1; k < NREG; k++) begin
      vec_t v;
      v = '0;
      v.iv = 1'b1; v.dv = 1'b1; v.d = 3'(k);
      v.ed = 1'b1;
      model = model | (8'h01 << k);
      v.ep = model;
      step(v, 100 + k);
    end
    for (int k = 0; k < NREG - 1; k++) begin
      vec_t v;
      logic [2:0] gone;
      gone = 3'(((k * 3) % 7) + 1);
      v = '0;
      v.c0v = 1'b1; v.c0 = gone;
      // R2 read a register that is still pending after this clear
      v.iv = 1'b1; v.sv = 1'b1; v.s = 3'(((((k + 1) * 3) % 7) + 1));
      v.dv = 1'b0;
      model = model & ~(8'h01 << gone);
      v.ed = (k == NREG - 2);
      v.es = !v.ed;
      v.ep = model;
      step(v, 200 + k);
    end

    // R1 reset mid-run: mark r5, then reset with an instruction presented
    @(negedge clk);
    idle_inputs();
    in_valid = 1'b1; rd_vld = 1'b1; rd_idx = 3'd5;
    @(posedge clk);
    #1;
    check(pending == 8'h20, "R4 mark before reset", pending, 8'h20);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(pending == 8'h00, "R1 async clear", pending, 0);
    check(dispatch == 1'b0, "R1 no grant in reset", dispatch, 0);
    check(stall == 1'b1, "R1 stall in reset", stall, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(dispatch == 1'b0, "R1 no grant one edge after release", dispatch, 0);
    @(negedge clk);
    #1;
    check(dispatch == 1'b1, "R1 grant two edges after release", dispatch, 1);
    @(posedge clk);
    #1;
    check(pending == 8'h20, "R1 R4 mark after release", pending, 8'h20);
    @(negedge clk);
    idle_inputs();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule